// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a stream of 32.768 kHz time-base enable pulses into periodic interrupt ticks. A 4-bit rate code picks the tick period as a power of two of time-base pulses. Each tick sets two flags in an 8-bit status image and drives an interrupt request, which stays high until software strobes a clear.

The divider runs only when the rate code is nonzero and the periodic enable is set. It also runs when the square-wave enable is set together with the square-wave interrupt option. Any change of the effective period, including one caused by starting the divider, restarts the count from zero. The first tick after a change therefore arrives one full new period later.

Top module: `periodic_irq_divider`

## Requirements
- R1: After reset `tick_o`, `irq_o` and every bit of `stat_o` are 0.
- R2: With `rate_code_i` equal to 0 no tick is produced, whatever the enable inputs.
- R3: For rate codes 3 to 15 the spacing between consecutive ticks is 2^(code-1) time-base pulses (4 pulses for code 3, 16384 for code 15).
- R4: Rate code 1 gives the same period as code 8 (128 pulses), and rate code 2 the same as code 9 (256 pulses).
- R5: The count advances only on clock cycles where `tb_en_i` is 1. With pulses every third cycle and code 3, ticks are 12 cycles apart. With no pulses there are no ticks.
- R6: The divider runs when `pie_i` is 1, or when both `sqwe_i` and `sqw_irq_en_i` are 1. Otherwise it produces no tick.
- R7: When the effective period changes, the count restarts. With a continuous time base the first tick is seen p+1 clock edges after the edge that first samples the new code, where p is the new period.
- R8: A tick sets bit 7 (master flag) and bit 6 (periodic flag) of `stat_o` in the same cycle that `tick_o` is high. Bits 5..0 are always 0, and `irq_o` always equals bit 7.
- R9: A `clr_i` strobe clears both flags and `irq_o` at the next edge. If a tick falls on the same edge, the tick wins and the flags stay set.
- R10: `tick_o` is high for exactly one clock cycle per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_en_i | input | 1 | One-cycle enable per 32.768 kHz time-base period |
| rate_code_i | input | 4 | Rate select code |
| pie_i | input | 1 | Periodic interrupt enable |
| sqwe_i | input | 1 | Square-wave enable |
| sqw_irq_en_i | input | 1 | Square-wave interrupt option |
| clr_i | input | 1 | Status clear strobe (status read) |
| tick_o | output | 1 | Single-cycle tick pulse |
| stat_o | output | 8 | Status image: bit 7 master flag, bit 6 periodic flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Tick, flags and irq all come from registers that update on the edge where the last counted pulse is sampled. They are visible together one edge after that pulse. A rate change costs one extra edge for the restart.

The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the stimulus to the first tick, and expects p+1 edges after a change and p edges between steady ticks. A clear is checked one edge after the strobe.

The tick-wins case is timed so that the strobe sits on the fourth edge after a code-3 tick.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int RATE_W      = 4;
  localparam int STAT_W      = 8;
  localparam int MASTER_BIT  = 7;
  localparam int PERIOD_BIT  = 6;
  localparam int ALIAS_MAX   = 2;
  localparam int ALIAS_SHIFT = 7;

  typedef struct packed {
    logic master;
    logic period;
  } flag_t;
endpackage

// File: rtl/pid_rate_decode.sv
module pid_rate_decode #(
  parameter int RATE_W = pid_pkg::RATE_W
) (
  input  logic [RATE_W-1:0] code_i,
  input  logic              pie_i,
  input  logic              sqwe_i,
  input  logic              sqw_irq_en_i,
  output logic              run_o,
  output logic [RATE_W-1:0] exp_o
);
  logic [RATE_W-1:0] eff;

  always_comb begin
    eff = code_i;
    if (code_i != '0 && code_i <= RATE_W'(pid_pkg::ALIAS_MAX))
      eff = code_i + RATE_W'(pid_pkg::ALIAS_SHIFT);
    // code 0 wraps to all ones, which no running code reaches
    exp_o = eff - RATE_W'(1);
    run_o = (code_i != '0) && (pie_i || (sqwe_i && sqw_irq_en_i));
  end
endmodule

// File: rtl/pid_tick_counter.sv
module pid_tick_counter #(
  parameter int EXP_W = pid_pkg::RATE_W,
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tb_en_i,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             hit_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] exp_q;
  logic             tick_q;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   last;
  logic             restart;

  always_comb begin
    span    = {{CNT_W{1'b0}}, 1'b1} << exp_i;
    last    = span - {{CNT_W{1'b0}}, 1'b1};
    restart = !run_i || (exp_i != exp_q);
    hit_o   = !restart && tb_en_i && (cnt_q == last[CNT_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      exp_q  <= '1;
      tick_q <= 1'b0;
    end else begin
      exp_q  <= exp_i;
      tick_q <= hit_o;
      if (restart || hit_o) cnt_q <= '0;
      else if (tb_en_i)     cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pid_status.sv
module pid_status #(
  parameter int STAT_W = pid_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  pid_pkg::flag_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (set_i) flags_q <= '{master: 1'b1, period: 1'b1};
    else if (clr_i) flags_q <= '0;
  end

  always_comb begin
    stat_o = '0;
    stat_o[pid_pkg::MASTER_BIT] = flags_q.master;
    stat_o[pid_pkg::PERIOD_BIT] = flags_q.period;
  end

  assign irq_o = flags_q.master;
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider #(
  parameter int RATE_W = pid_pkg::RATE_W,
  parameter int STAT_W = pid_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_en_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic              pie_i,
  input  logic              sqwe_i,
  input  logic              sqw_irq_en_i,
  input  logic              clr_i,
  output logic              tick_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  localparam int CNT_W = (2 ** RATE_W) - 2;

  logic              run;
  logic [RATE_W-1:0] exp_sel;
  logic              hit;

  pid_rate_decode #(.RATE_W(RATE_W)) u_dec (
    .code_i      (rate_code_i),
    .pie_i       (pie_i),
    .sqwe_i      (sqwe_i),
    .sqw_irq_en_i(sqw_irq_en_i),
    .run_o       (run),
    .exp_o       (exp_sel)
  );

  pid_tick_counter #(.EXP_W(RATE_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tb_en_i(tb_en_i),
    .run_i  (run),
    .exp_i  (exp_sel),
    .hit_o  (hit),
    .tick_o (tick_o)
  );

  pid_status #(.STAT_W(STAT_W)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit),
    .clr_i (clr_i),
    .stat_o(stat_o),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
  parameter int RATE_W = pid_pkg::RATE_W,
  parameter int STAT_W = pid_pkg::STAT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tb_en_i,
  input logic [RATE_W-1:0] rate_code_i,
  input logic              clr_i,
  input logic              tick_o,
  input logic [STAT_W-1:0] stat_o,
  input logic              irq_o
);
  localparam int MB = pid_pkg::MASTER_BIT;
  localparam int PB = pid_pkg::PERIOD_BIT;

  AST_ZERO_CODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_code_i == '0 |=> !tick_o); // R2
  AST_TICK_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(tb_en_i)); // R5
  AST_TICK_SETS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (stat_o[MB] && stat_o[PB] && irq_o)); // R8
  AST_IRQ_TRACKS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == stat_o[MB]); // R8
  AST_SPARE_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stat_o) == ($countones(stat_o[MB]) + $countones(stat_o[PB]))); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tick_o || stat_o == '0)); // R9
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R10
endmodule

bind periodic_irq_divider pid_checker #(.RATE_W(RATE_W), .STAT_W(STAT_W)) u_pid_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tb_en_i    (tb_en_i),
  .rate_code_i(rate_code_i),
  .clr_i      (clr_i),
  .tick_o     (tick_o),
  .stat_o     (stat_o),
  .irq_o      (irq_o)
);

// File: tb/tb_periodic_irq_divider.sv
module tb_periodic_irq_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic [3:0] code = 4'd0;
  logic       pie = 1'b0;
  logic       sqwe = 1'b0;
  logic       sqw_opt = 1'b0;
  logic       clr = 1'b0;
  logic       tick;
  logic [7:0] stat;
  logic       irq;

  int gap = 1;   // 0: no pulses, 1: every cycle, n: every n-th cycle
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  periodic_irq_divider dut (
    .clk_i(clk), .rst_ni(rst_n), .tb_en_i(tb_en), .rate_code_i(code),
    .pie_i(pie), .sqwe_i(sqwe), .sqw_irq_en_i(sqw_opt), .clr_i(clr),
    .tick_o(tick), .stat_o(stat), .irq_o(irq)
  );

  initial begin : pulse_gen
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      if (gap == 0) tb_en = 1'b0;
      else begin
        tb_en = (phase == 0);
        phase = (phase + 1 >= gap) ? 0 : phase + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // falling edges until tick_o seen high, capped at lim+1
  task automatic to_tick(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n <= lim);
  endtask

  task automatic count_ticks(input int cycles, output int k);
    k = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) k++;
    end
  endtask

  function automatic int period_of(input int c);
    int e;
    e = (c <= 2) ? c + 7 : c;
    return 1 << (e - 1);
  endfunction

  task automatic sweep_code(input int c, input string req);
    int n;
    int p;
    p = period_of(c);
    code = 4'd0;
    @(negedge clk);
    @(negedge clk);
    code = c[3:0];
    to_tick(p + 2, n);
    check(n == p + 1, req, n, p + 1);
    to_tick(p + 2, n);
    check(n == p, req, n, p);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tick == 1'b0 && stat == 8'h00 && irq == 1'b0, "R1", int'(stat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0 && stat == 8'h00 && irq == 1'b0, "R1", int'(stat), 0);

    // R2 code 0 with every enable on
    pie = 1'b1; sqwe = 1'b1; sqw_opt = 1'b1;
    count_ticks(60, k);
    check(k == 0, "R2", k, 0);
    check(stat == 8'h00, "R2", int'(stat), 0);
    sqwe = 1'b0; sqw_opt = 1'b0;

    // R3 and R7 sweep of direct codes, each started from code 0
    for (int c = 3; c <= 15; c++) sweep_code(c, "R3/R7");

    // R4 aliased codes
    sweep_code(1, "R4");
    sweep_code(2, "R4");
    sweep_code(8, "R4");
    sweep_code(9, "R4");

    // R7 change mid-count
    code = 4'd15;
    repeat (100) @(negedge clk);
    code = 4'd3;
    to_tick(10, n);
    check(n == 5, "R7", n, 5);
    code = 4'd4;
    to_tick(12, n);
    check(n == 9, "R7", n, 9);

    // R10 single-cycle pulse, R8 flag image
    code = 4'd3;
    to_tick(10, n);
    check(stat == 8'hC0 && irq == 1'b1, "R8", int'(stat), 8'hC0);
    @(negedge clk);
    check(tick == 1'b0, "R10", int'(tick), 0);
    check(stat == 8'hC0 && irq == 1'b1, "R8", int'(stat), 8'hC0);

    // R9 clear, then clear colliding with a tick
    to_tick(10, n);
    clr = 1'b1;
    @(negedge clk);
    check(stat == 8'h00 && irq == 1'b0, "R9", int'(stat), 0);
    clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    check(tick == 1'b1, "R9", int'(tick), 1);
    check(stat == 8'hC0 && irq == 1'b1, "R9", int'(stat), 8'hC0);
    clr = 1'b0;

    // R6 enable combinations at code 3
    pie = 1'b0; sqwe = 1'b1; sqw_opt = 1'b0;
    count_ticks(40, k);
    check(k == 0, "R6", k, 0);
    sqwe = 1'b0; sqw_opt = 1'b1;
    count_ticks(40, k);
    check(k == 0, "R6", k, 0);
    sqwe = 1'b1;
    to_tick(10, n);
    to_tick(10, n);
    check(n == 4, "R6", n, 4);
    sqwe = 1'b0; sqw_opt = 1'b0; pie = 1'b1;

    // R5 gapped and absent time base
    gap = 3;
    to_tick(40, n);
    to_tick(40, n);
    check(n == 12, "R5", n, 12);
    to_tick(40, n);
    check(n == 12, "R5", n, 12);
    gap = 0;
    count_ticks(60, k);
    check(k == 0, "R5", k, 0);
    gap = 1;

    // R2 stopping a running divider
    code = 4'd0;
    count_ticks(40, k);
    check(k == 0, "R2", k, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule